// File: doc/BRIEF.md
# Energy-per-operation sensing controller

This controller estimates how much energy a load circuit spends on each operation, and it needs no analog-to-digital converter to do so. A sense cycle starts with a request. The controller first turns off the supply converter, so that the load runs only from its storage capacitor. It then lets the load complete a chosen number of operations, either 32 or 64. The supply sags over those operations. The controller next switches on a constant current sink. It counts fixed-clock cycles for as long as an external comparator reports that the crossing point has not yet been reached, and that count is proportional to the supply drop.

The drop is small next to the starting voltage. The starting voltage is the converter reference, and its digital code is already inside the controller. The energy estimate is therefore the cycle count multiplied by that reference code, with no other scaling. The result is a normalized 13-bit figure that a voltage-tracking loop can compare between settings. A single-cycle valid pulse marks each new result. The converter is turned back on in that same cycle.

The controller is a five-state machine:

- **IDLE**: the converter is enabled. A request leads to **PREP**, and the reference code and the operation-count choice are captured.
- **PREP**: the converter is disabled and both counters are cleared. The machine always moves on to **OPS**.
- **OPS**: the controller counts rising edges of the operation strobe. The Nth edge leads to **SINK**.
- **SINK**: the current sink is on and droop cycles are counted. A low comparator sample, or a high sample taken when the count is already at its maximum, leads to **DONE**.
- **DONE**: the product is registered. The machine always returns to **IDLE**, where the valid pulse appears.

Top module: `energy_sense_ctrl`

## Requirements
- R1: After reset, conv_dis, sink_en, est_valid, est_ovf and est are all 0.
- R2: A request sampled in IDLE raises conv_dis in the next cycle. conv_dis stays high until the estimate is delivered, and it is low in the cycle where est_valid is high.
- R3: Only rising edges of op_done are counted, so a strobe held high for several cycles counts once. The sink phase begins right after the Nth edge. N is 32 when n_sel is 0 and 64 when n_sel is 1, and the value is captured at the accepted request.
- R4: sink_en is high only while conv_dis is high. With cmp_in high (crossing not yet reached) for the first D sampled sink cycles and low afterwards, sink_en lasts D+1 cycles for D up to 63.
- R5: est equals min(D,63) multiplied by the 7-bit reference code captured at the accepted request. Changes to ref_code after the request have no effect on that result.
- R6: The droop count saturates at 63 and does not wrap. If cmp_in is still high when the count is 63, the sink phase ends after 64 cycles, est_ovf is 1, and est equals 63 times the code. Otherwise est_ovf is 0.
- R7: est_valid is a one-cycle pulse. est and est_ovf hold their values until the next estimate.
- R8: A request that arrives while a cycle is running has no effect. Exactly one estimate results, and the converter is enabled and the sink is off in the cycle after valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-frequency clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sense_req | input | 1 | Start a sense cycle (taken only in IDLE) |
| n_sel | input | 1 | Operation count: 0 gives 32, 1 gives 64 |
| op_done | input | 1 | Operation strobe from the load |
| cmp_in | input | 1 | Comparator: 1 while the crossing has not been reached |
| ref_code | input | 7 | Current converter reference code |
| conv_dis | output | 1 | Disable the supply converter |
| sink_en | output | 1 | Enable the constant current sink |
| est | output | 13 | Energy estimate: droop count times reference code |
| est_valid | output | 1 | One-cycle pulse marking a new estimate |
| est_ovf | output | 1 | The droop count saturated during this cycle |

## Verification
The bench builds the controller with its default parameters: a 7-bit code, a 6-bit droop count and operation counts of 32 and 64. A 6-bit droop count lets a sweep of the comparator-high duration from 0 to 70 cycles walk straight across the saturation edge at 63 and 64 cycles. Each run of the sweep varies the reference code, the operation count, the strobe width and the presence of stray requests. Extra runs at code 127 reach the full 13-bit product range, and runs at code 0 check a zero result.

// File: rtl/esense_pkg.sv
package esense_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_OPS,
        ST_SINK,
        ST_DONE
    } esense_state_t;
endpackage

// File: rtl/esense_opcount.sv
module esense_opcount #(
    parameter int N_SHORT = 32,
    parameter int N_LONG  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic op_in,
    input  logic long_sel,
    output logic reached
);
    localparam int CW = $clog2(N_LONG + 1);

    logic          op_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] target;
    logic          rise;

    always_comb begin
        target  = long_sel ? CW'(N_LONG) : CW'(N_SHORT);
        rise    = op_in & ~op_q;
        reached = enable & rise & (cnt_q == target - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            op_q <= op_in;
            if (clear)
                cnt_q <= '0;
            else if (enable && rise)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    op_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (cnt_q < target));
endmodule

// File: rtl/esense_droop.sv
module esense_droop #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             cmp_in,
    output logic [CNT_W-1:0] cnt,
    output logic             saturate,
    output logic             finish
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt      = cnt_q;
        saturate = enable & cmp_in & (cnt_q == CNT_MAX);
        finish   = enable & ~cmp_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (enable && cmp_in && (cnt_q != CNT_MAX))
            cnt_q <= cnt_q + 1'b1;
    end

    // R6
    droop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/energy_sense_ctrl.sv
module energy_sense_ctrl
    import esense_pkg::*;
#(
    parameter int REF_W   = 7,
    parameter int CNT_W   = 6,
    parameter int N_SHORT = 32,
    parameter int N_LONG  = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sense_req,
    input  logic                   n_sel,
    input  logic                   op_done,
    input  logic                   cmp_in,
    input  logic [REF_W-1:0]       ref_code,
    output logic                   conv_dis,
    output logic                   sink_en,
    output logic [REF_W+CNT_W-1:0] est,
    output logic                   est_valid,
    output logic                   est_ovf
);
    localparam int               EST_W   = REF_W + CNT_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    esense_state_t    state_q, state_d;
    logic [REF_W-1:0] ref_q;
    logic             long_q;
    logic             ovf_seen_q;
    logic [EST_W-1:0] est_q;
    logic             valid_q;
    logic             ovf_q;

    logic             cnt_clear, ops_en;
    logic             ops_reached;
    logic [CNT_W-1:0] droop_cnt;
    logic             droop_sat, droop_fin;

    esense_opcount #(.N_SHORT(N_SHORT), .N_LONG(N_LONG)) u_opcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .enable   (ops_en),
        .op_in    (op_done),
        .long_sel (long_q),
        .reached  (ops_reached)
    );

    esense_droop #(.CNT_W(CNT_W)) u_droop (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .enable   (sink_en),
        .cmp_in   (cmp_in),
        .cnt      (droop_cnt),
        .saturate (droop_sat),
        .finish   (droop_fin)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sense_req) state_d = ST_PREP;
            ST_PREP: state_d = ST_OPS;
            ST_OPS:  if (ops_reached) state_d = ST_SINK;
            ST_SINK: if (droop_fin || droop_sat) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        conv_dis  = 1'b1;
        sink_en   = 1'b0;
        cnt_clear = 1'b0;
        ops_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: conv_dis  = 1'b0;
            ST_PREP: cnt_clear = 1'b1;
            ST_OPS:  ops_en    = 1'b1;
            ST_SINK: sink_en   = 1'b1;
            ST_DONE: ;
            default: conv_dis  = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q      <= '0;
            long_q     <= 1'b0;
            ovf_seen_q <= 1'b0;
            est_q      <= '0;
            valid_q    <= 1'b0;
            ovf_q      <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && sense_req) begin
                ref_q  <= ref_code;
                long_q <= n_sel;
            end
            if (cnt_clear)
                ovf_seen_q <= 1'b0;
            else if (droop_sat)
                ovf_seen_q <= 1'b1;
            valid_q <= (state_q == ST_DONE);
            if (state_q == ST_DONE) begin
                est_q <= EST_W'(droop_cnt) * EST_W'(ref_q);
                ovf_q <= ovf_seen_q;
            end
        end
    end

    assign est       = est_q;
    assign est_valid = valid_q;
    assign est_ovf   = ovf_q;

    // R4
    sink_only_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sink_en |-> conv_dis);

    // R2
    disable_before_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sink_en) |-> $past(conv_dis));

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |=> !est_valid);

    // R8
    busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_req && state_q != ST_IDLE) |=> (state_q != ST_PREP));

    // R6
    ovf_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (est_valid && est_ovf) |-> (est == EST_W'(CNT_MAX) * EST_W'(ref_q)));
endmodule

// File: tb/test_energy_sense_ctrl.sv
module test_energy_sense_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sense_req = 1'b0;
    logic        n_sel = 1'b0;
    logic        op_done = 1'b0;
    logic        cmp_in = 1'b1;
    logic [6:0]  ref_code = '0;
    logic        conv_dis, sink_en, est_valid, est_ovf;
    logic [12:0] est;

    int n_checks = 0;
    int n_fail = 0;
    int d_cur = 0;
    int sc = 0;
    int sink_cycles = 0;
    int viol = 0;
    bit finished = 1'b0;

    energy_sense_ctrl i_energy_sense_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sense_req (sense_req),
        .n_sel     (n_sel),
        .op_done   (op_done),
        .cmp_in    (cmp_in),
        .ref_code  (ref_code),
        .conv_dis  (conv_dis),
        .sink_en   (sink_en),
        .est       (est),
        .est_valid (est_valid),
        .est_ovf   (est_ovf)
    );

    always #10 clk = ~clk;

    // Comparator and current-sink model: high for the first d_cur sink cycles.
    always @(negedge clk) begin
        if (sink_en) begin
            cmp_in = (sc < d_cur);
            sc++;
            sink_cycles++;
            if (!conv_dis) viol++;
        end else begin
            sc = 0;
            cmp_in = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int w, input bit stray);
        repeat (w) begin
            @(negedge clk);
            op_done = 1'b1;
            sense_req = stray;
        end
        @(negedge clk);
        op_done = 1'b0;
        sense_req = 1'b0;
    endtask

    task automatic run(input int d, input int rc, input bit ns, input int w, input bit stray);
        int n;
        int expc;
        int exps;
        int t;
        bit expo;
        n    = ns ? 64 : 32;
        expc = (d > 63) ? 63 : d;
        expo = (d > 63);
        exps = (d > 63) ? 64 : d + 1;
        d_cur = d;
        sink_cycles = 0;
        viol = 0;
        @(negedge clk);
        ref_code = 7'(rc);
        n_sel = ns;
        sense_req = 1'b1;
        @(negedge clk);
        sense_req = 1'b0;
        // R2: converter disabled the cycle after the request
        chk(conv_dis == 1'b1, "R2 conv_dis after request", int'(conv_dis), 1);
        // R5 / R3: later changes to code and count choice must not matter
        ref_code = ~7'(rc);
        n_sel = ~ns;
        for (int i = 0; i < n - 1; i++) pulse(w, stray && (i == 5));
        // R3: no sink before the Nth rising edge
        chk(sink_en == 1'b0 && sink_cycles == 0, "R3 sink before Nth edge", sink_cycles, 0);
        pulse(w, 1'b0);
        t = 0;
        while (!est_valid && t < 400) begin
            @(negedge clk);
            t++;
        end
        // R7
        chk(est_valid == 1'b1, "R7 valid seen", int'(est_valid), 1);
        // R5 / R6
        chk(int'(est) == expc * rc, "R5 estimate value", int'(est), expc * rc);
        chk(est_ovf == expo, "R6 overflow flag", int'(est_ovf), int'(expo));
        // R4 / R6: sink window length
        chk(sink_cycles == exps, "R4 sink window length", sink_cycles, exps);
        chk(viol == 0, "R4 sink only while disabled", viol, 0);
        // R2: converter re-enabled when estimate delivered
        chk(conv_dis == 1'b0, "R2 conv_dis at valid", int'(conv_dis), 0);
        @(negedge clk);
        // R7: single-cycle pulse, values held
        chk(est_valid == 1'b0, "R7 valid single cycle", int'(est_valid), 0);
        chk(int'(est) == expc * rc, "R7 estimate held", int'(est), expc * rc);
        // R8: stray requests started no new cycle
        chk(conv_dis == 1'b0 && sink_en == 1'b0, "R8 idle after estimate",
            int'({conv_dis, sink_en}), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(conv_dis == 0 && sink_en == 0 && est_valid == 0 && est_ovf == 0 && est == 0,
            "R1 reset state", int'({conv_dis, sink_en, est_valid, est_ovf}) + int'(est), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(conv_dis == 0 && sink_en == 0, "R1 idle after reset", int'({conv_dis, sink_en}), 0);
        for (int d = 0; d <= 70; d++)
            run(d, (d * 37 + 11) % 128, 1'(d % 2), 1 + (d % 3), (d % 4) == 1);
        run(63, 127, 1'b0, 1, 1'b0);
        run(64, 127, 1'b1, 2, 1'b1);
        run(40, 0, 1'b0, 3, 1'b0);
        run(1, 127, 1'b1, 1, 1'b0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule